// File: doc/BRIEF.md
# Configurable Burst Read Port

This block is the device side of a parallel read port. It holds a 16-bit read configuration word that decides how reads behave. After reset the port runs in page mode: the address presented at every clock edge comes back as a data word one cycle later, and WAIT stays released. When the host clears the mode bit, the port switches to a clocked burst. An address-valid strobe captures a start address. The port then waits a programmed number of clock edges, raises WAIT while it waits, and streams words in an address order that the configuration word selects.

Every part of the burst is set at run time by fields of the configuration word: the latency, the WAIT polarity and its lead time, the clock edge that launches data, the wrap behaviour and the burst length. A read of the configuration word itself goes through the same path. In burst mode it repeats one word for the whole burst. In page mode only the word that follows the strobe is valid. The read data comes from a fixed stub: the word for address `a` is the low address byte written twice and XOR-ed with 0x3C5A.

Top module: `flash_burst_reader`

## Requirements
- R1: While `rst` is high and right after it falls, `data_valid` is 0 and `wait_o` is 1. The configuration word reads back as 0xF94F: page mode, latency 15, WAIT active low, WAIT early, rising edge, no wrap, continuous.
- R2: In page mode (bit 15 = 1), the cycle after each rising edge shows `data_out` equal to word(`addr` at that edge) with `data_valid` = 1, and WAIT stays deasserted.
- R3: A write with `cfg_we` stores `cfg_wdata`, with bits 9, 7, 5 and 4 forced to 0. A latency code of 0 or 1 in bits 14:11 leaves the stored latency unchanged. A length code of 0, 4, 5 or 6 in bits 2:0 leaves the stored length unchanged.
- R4: In burst mode (bit 15 = 0) with latency code L, a strobe sampled at edge 0 gives the first valid word in the cycle that follows edge L, and no valid word before that.
- R5: With bit 8 = 0, the logical WAIT is asserted after edges 1 to L-1 and is released together with the first valid word. With bit 8 = 1 it is released one cycle earlier, after edges 1 to L-2 only.
- R6: Bit 10 = 0 drives `wait_o` low when asserted and high otherwise. Bit 10 = 1 inverts this.
- R7: Length codes 1, 2 and 3 give 4, 8 and 16 consecutive valid words. `data_valid` is 0 afterwards, with WAIT released. Code 7 streams words without end.
- R8: With bit 3 = 0 and a finite length N, word j of the burst comes from address (start with its low log2(N) bits cleared) OR ((start + j) mod N).
- R9: With bit 3 = 1, or with a continuous burst, word j comes from (start + j) mod 256.
- R10: A strobe with `cfg_sel` = 1 reads the configuration word. In burst mode every word of the burst equals that word. In page mode only the word right after the strobe is valid, and later cycles with `cfg_sel` held high show `data_valid` = 0.
- R11: With bit 6 = 1, outputs change just after the rising edge. With bit 6 = 0, they change at the following falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Load configuration word |
| cfg_wdata | input | 16 | Configuration word to load |
| adv | input | 1 | Address-valid strobe, starts a burst |
| cfg_sel | input | 1 | Read the configuration word instead of the array |
| addr | input | 8 | Read address |
| data_out | output | 16 | Read data |
| data_valid | output | 1 | Read data is valid |
| wait_o | output | 1 | WAIT handshake, polarity set by bit 10 |

## Verification
The hardest case to reach is a wrapped burst whose start address sits near the end of its aligned window. The bench starts 4-word and 16-word wrapped bursts two and three words below the window end, and compares them with a linear 8-word burst from the same start that crosses the boundary. The WAIT lead and the falling-edge launch show only within single cycles. The bench samples at three quarters of each period, and additionally a quarter period after the edge that yields the first word.

// File: rtl/frd_pkg.sv
package frd_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 8;
    localparam int LAT_W  = 4;
    localparam int BEAT_W = 5;

    localparam logic [DATA_W-1:0] CFG_RESET = 16'hF94F;
    localparam logic [DATA_W-1:0] CFG_WMASK = 16'hFD4F;

    typedef struct packed {
        logic             rm;
        logic [LAT_W-1:0] lc;
        logic             wpol;
        logic             wdly;
        logic             ce;
        logic             nowrap;
        logic [2:0]       bl;
    } cfg_t;

    function automatic logic [BEAT_W-1:0] burst_words(input logic [2:0] bl);
        case (bl)
            3'd1:    return 5'd4;
            3'd2:    return 5'd8;
            3'd3:    return 5'd16;
            default: return 5'd0;
        endcase
    endfunction

    function automatic logic bl_legal(input logic [2:0] bl);
        return (bl == 3'd1) || (bl == 3'd2) || (bl == 3'd3) || (bl == 3'd7);
    endfunction

    function automatic logic [DATA_W-1:0] word_of(input logic [7:0] a);
        return {a, a} ^ 16'h3C5A;
    endfunction
endpackage

// File: rtl/frd_cfg_reg.sv
module frd_cfg_reg
    import frd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cfg_q
);
    logic [DATA_W-1:0] nxt;

    always_comb begin
        nxt = wdata & CFG_WMASK;
        if (wdata[14:11] < 4'd2) nxt[14:11] = cfg_q[14:11];
        if (!bl_legal(wdata[2:0])) nxt[2:0] = cfg_q[2:0];
    end

    always_ff @(posedge clk) begin
        if (rst)     cfg_q <= CFG_RESET;
        else if (we) cfg_q <= nxt;
    end

    p_lc_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (we && wdata[14:11] < 4'd2) |=> $stable(cfg_q[14:11]));
    p_bl_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (we && !bl_legal(wdata[2:0])) |=> $stable(cfg_q[2:0]));
endmodule

// File: rtl/frd_burst_seq.sv
module frd_burst_seq
    import frd_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rm,
    input  logic [LAT_W-1:0] lc,
    input  logic             nowrap,
    input  logic [2:0]       bl,
    input  logic             adv,
    input  logic             cfg_sel,
    input  logic [AW-1:0]    addr,
    output logic [AW-1:0]    rd_addr,
    output logic             csel,
    output logic             active,
    output logic             ready,
    output logic             early
);
    logic [LAT_W-1:0]  cnt;
    logic [BEAT_W-1:0] beat;
    logic [BEAT_W-1:0] len;
    logic [AW-1:0]     mask;
    logic [AW-1:0]     nxt_addr;
    logic              wrap_en;

    always_comb begin
        len      = burst_words(bl);
        mask     = AW'(len - 5'd1);
        wrap_en  = !nowrap && (len != 5'd0);
        nxt_addr = wrap_en ? ((rd_addr & ~mask) | ((rd_addr + AW'(1)) & mask))
                           : rd_addr + AW'(1);
        ready    = active && (cnt == '0);
        early    = active && (cnt <= LAT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            cnt     <= '0;
            beat    <= '0;
            rd_addr <= '0;
            csel    <= 1'b0;
        end else if (adv && !rm) begin
            active  <= 1'b1;
            cnt     <= LAT_W'(lc - 4'd1);
            beat    <= '0;
            rd_addr <= addr;
            csel    <= cfg_sel;
        end else if (adv) begin
            active  <= 1'b0;
        end else if (active && cnt != '0) begin
            cnt     <= LAT_W'(cnt - 4'd1);
        end else if (active) begin
            if (len != 5'd0 && beat == BEAT_W'(len - 5'd1)) active <= 1'b0;
            beat    <= BEAT_W'(beat + 5'd1);
            rd_addr <= nxt_addr;
        end
    end

    p_lat_countdown_r4: assert property (@(posedge clk) disable iff (rst)
        (active && cnt != '0 && !adv) |=> (cnt == LAT_W'($past(cnt) - 4'd1)));
    p_wrap_window_r8: assert property (@(posedge clk) disable iff (rst)
        (ready && !adv && wrap_en) |=>
        (!active || ((rd_addr & ~$past(mask)) == ($past(rd_addr) & ~$past(mask)))));
    p_burst_stop_r7: assert property (@(posedge clk) disable iff (rst)
        (ready && !adv && len != 5'd0 && beat == BEAT_W'(len - 5'd1)) |=> !active);
endmodule

// File: rtl/frd_out_stage.sv
module frd_out_stage
    import frd_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rm,
    input  logic              wpol,
    input  logic              wdly,
    input  logic              ce,
    input  logic [DATA_W-1:0] cfg_word,
    input  logic              adv,
    input  logic              cfg_sel,
    input  logic [AW-1:0]     addr,
    input  logic [AW-1:0]     rd_addr,
    input  logic              csel,
    input  logic              active,
    input  logic              ready,
    input  logic              early,
    output logic [DATA_W-1:0] data_out,
    output logic              data_valid,
    output logic              wait_o
);
    logic [DATA_W-1:0] d_r, d_f;
    logic              v_r, v_f, w_r, w_f;
    logic              w_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            d_r <= '0;
            v_r <= 1'b0;
            w_r <= 1'b0;
        end else if (rm) begin
            d_r <= cfg_sel ? cfg_word : word_of(8'(addr));
            v_r <= cfg_sel ? adv : 1'b1;
            w_r <= 1'b0;
        end else begin
            if (ready) d_r <= csel ? cfg_word : word_of(8'(rd_addr));
            v_r <= ready;
            w_r <= wdly ? (active && !early) : (active && !ready);
        end
    end

    always_ff @(negedge clk) begin
        if (rst) begin
            d_f <= '0;
            v_f <= 1'b0;
            w_f <= 1'b0;
        end else begin
            d_f <= d_r;
            v_f <= v_r;
            w_f <= w_r;
        end
    end

    always_comb begin
        data_out   = ce ? d_r : d_f;
        data_valid = ce ? v_r : v_f;
        w_sel      = ce ? w_r : w_f;
        wait_o     = wpol ? w_sel : !w_sel;
    end

    p_wait_clear_on_data_r5: assert property (@(posedge clk) disable iff (rst)
        v_r |-> !w_r);
    p_page_no_wait_r2: assert property (@(posedge clk) disable iff (rst)
        rm |=> !w_r);
endmodule

// File: rtl/flash_burst_reader.sv
module flash_burst_reader
    import frd_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              adv,
    input  logic              cfg_sel,
    input  logic [AW-1:0]     addr,
    output logic [DATA_W-1:0] data_out,
    output logic              data_valid,
    output logic              wait_o
);
    logic [DATA_W-1:0] cfg_word;
    cfg_t              cfg;
    logic [AW-1:0]     rd_addr;
    logic              csel, active, ready, early;

    always_comb begin
        cfg.rm     = cfg_word[15];
        cfg.lc     = cfg_word[14:11];
        cfg.wpol   = cfg_word[10];
        cfg.wdly   = cfg_word[8];
        cfg.ce     = cfg_word[6];
        cfg.nowrap = cfg_word[3];
        cfg.bl     = cfg_word[2:0];
    end

    frd_cfg_reg u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata), .cfg_q(cfg_word)
    );

    frd_burst_seq #(.AW(AW)) u_seq (
        .clk(clk), .rst(rst), .rm(cfg.rm), .lc(cfg.lc), .nowrap(cfg.nowrap),
        .bl(cfg.bl), .adv(adv), .cfg_sel(cfg_sel), .addr(addr),
        .rd_addr(rd_addr), .csel(csel), .active(active), .ready(ready), .early(early)
    );

    frd_out_stage #(.AW(AW)) u_out (
        .clk(clk), .rst(rst), .rm(cfg.rm), .wpol(cfg.wpol), .wdly(cfg.wdly),
        .ce(cfg.ce), .cfg_word(cfg_word), .adv(adv), .cfg_sel(cfg_sel),
        .addr(addr), .rd_addr(rd_addr), .csel(csel), .active(active),
        .ready(ready), .early(early), .data_out(data_out),
        .data_valid(data_valid), .wait_o(wait_o)
    );
endmodule

// File: tb/flash_burst_reader_bench.sv
module flash_burst_reader_bench;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        adv = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [7:0]  addr = '0;
    logic [15:0] data_out;
    logic        data_valid;
    logic        wait_o;

    int n_tests = 0;
    int n_fail  = 0;

    flash_burst_reader u_flash_burst_reader (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .adv(adv), .cfg_sel(cfg_sel), .addr(addr), .data_out(data_out),
        .data_valid(data_valid), .wait_o(wait_o)
    );

    always #(PERIOD/2) clk = ~clk;

    function automatic logic [15:0] word(input logic [7:0] a);
        return {a, a} ^ 16'h3C5A;
    endfunction

    function automatic logic [15:0] mk(input bit rm, input int lc, input bit wp,
                                       input bit wd, input bit ce, input bit nw,
                                       input logic [2:0] bl);
        return {rm, 4'(lc), wp, 1'b0, wd, 1'b0, ce, 2'b00, nw, bl};
    endfunction

    function automatic logic [7:0] exp_addr(input logic [7:0] s, input int j,
                                            input int n, input bit wrap);
        logic [7:0] m;
        if (n == 0 || !wrap) return 8'(s + j);
        m = 8'(n - 1);
        return (s & ~m) | (8'(s + j) & m);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #7;
    endtask

    task automatic wr_cfg(input logic [15:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic read_cfg(input logic [15:0] exp, input string req);
        adv = 1'b1; cfg_sel = 1'b1;
        step();
        check(req, data_out, exp);
        check(req, data_valid, 1);
        adv = 1'b0;
        step();
        check("R10 page cfg single word", data_valid, 0);
        cfg_sel = 1'b0;
        step();
    endtask

    task automatic test_reset();
        step(); step();
        check("R1 valid in reset", data_valid, 0);
        check("R1 wait in reset", wait_o, 1);
        rst = 1'b0;
        check("R1 valid after reset", data_valid, 0);
        check("R1 wait after reset", wait_o, 1);
        read_cfg(16'hF94F, "R1 default cfg");
    endtask

    task automatic test_page();
        logic [7:0] list [5] = '{8'h00, 8'h01, 8'h7E, 8'hA5, 8'hFF};
        foreach (list[i]) begin
            addr = list[i];
            step();
            check("R2 page data", data_out, word(list[i]));
            check("R2 page valid", data_valid, 1);
            check("R2 page wait", wait_o, 1);
        end
    endtask

    task automatic test_cfg_write();
        wr_cfg(16'hFFFF);
        read_cfg(16'hFD4F, "R3 reserved bits cleared");
        wr_cfg(mk(1, 0, 0, 1, 1, 1, 3'b100));
        read_cfg(mk(1, 15, 0, 1, 1, 1, 3'd7), "R3 reserved codes kept");
        wr_cfg(mk(1, 1, 0, 0, 1, 0, 3'd2));
        read_cfg(mk(1, 15, 0, 0, 1, 0, 3'd2), "R3 lc 1 kept");
        wr_cfg(mk(1, 5, 1, 0, 0, 0, 3'd5));
        read_cfg(mk(1, 5, 1, 0, 0, 0, 3'd2), "R3 bl 5 kept");
        wr_cfg(16'hF94F);
    endtask

    task automatic run_burst(input logic [7:0] a, input bit sel, input int lat,
                             input int n, input bit wrap, input bit wd,
                             input bit pol, input logic [15:0] cw, input string tag);
        int total;
        bit ev, ewl;
        total = lat + ((n == 0) ? 12 : n) + 1;
        addr = a; cfg_sel = sel; adv = 1'b1;
        step();
        adv = 1'b0; cfg_sel = 1'b0;
        for (int k = 1; k <= total; k++) begin
            step();
            ev  = (k >= lat) && (n == 0 || k < lat + n);
            ewl = wd ? (k <= lat - 2) : (k <= lat - 1);
            check({tag, " R4 R7 valid"}, data_valid, ev);
            check({tag, " R5 R6 wait"}, wait_o, pol ? ewl : !ewl);
            if (ev)
                check({tag, " R8 R9 R10 data"}, data_out,
                      sel ? cw : word(exp_addr(a, k - lat, n, wrap)));
        end
    endtask

    task automatic test_bursts();
        logic [15:0] c;
        c = mk(0, 4, 0, 0, 1, 0, 3'd1); wr_cfg(c);
        run_burst(8'h0E, 0, 4, 4, 1, 0, 0, c, "wrap4");
        c = mk(0, 3, 1, 1, 1, 1, 3'd2); wr_cfg(c);
        run_burst(8'h0E, 0, 3, 8, 0, 1, 1, c, "linear8");
        c = mk(0, 2, 0, 0, 1, 0, 3'd3); wr_cfg(c);
        run_burst(8'h1D, 0, 2, 16, 1, 0, 0, c, "wrap16");
        c = mk(0, 5, 0, 1, 1, 0, 3'd7); wr_cfg(c);
        run_burst(8'hFC, 0, 5, 0, 0, 1, 0, c, "continuous");
        c = mk(0, 15, 1, 0, 1, 1, 3'd1); wr_cfg(c);
        run_burst(8'h33, 1, 15, 4, 0, 0, 1, c, "cfgread");
        wr_cfg(16'hF94F);
    endtask

    task automatic test_edge(input bit ce);
        wr_cfg(mk(0, 3, 0, 0, ce, 1, 3'd1));
        addr = 8'h40; adv = 1'b1;
        step();
        adv = 1'b0;
        step(); step();
        @(posedge clk);
        #2;
        check("R11 early quarter", data_valid, ce ? 1 : 0);
        #5;
        check("R11 late quarter", data_valid, 1);
        check("R11 data", data_out, word(8'h40));
        for (int i = 0; i < 5; i++) step();
        wr_cfg(16'hF94F);
    endtask

    initial begin
        #(PERIOD * 100000);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        test_reset();
        test_page();
        test_cfg_write();
        test_bursts();
        test_edge(1'b0);
        test_edge(1'b1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule